// File: doc/BRIEF.md
# Two-Bank Interleaved Video Memory Mapper

This block takes a byte address and a byte count on a linear view of video memory and turns them into a run of word accesses on two 32-bit memory banks. Linear 32-bit words alternate between the banks: a word with an even linear word index goes to bank 0 and an odd one to bank 1. Within its bank, a word sits at half its linear word index. The bank is picked by address bit 2 and the in-bank index is the address divided by 8. A transfer may start and end anywhere. The block splits it into an optional leading fragment that runs up to the next word boundary, a run of whole words, and an optional trailing fragment that starts at byte lane 0. Each piece is one bank access, with byte enables marking the active lanes.

Payload moves over a write stream and a read stream. Both use valid/ready. Each beat carries the bytes of one bank access, packed from lane 0, and `beat_bytes` gives how many bytes that is. On a write beat, the bank write happens only in the cycle where `wr_valid` and `wr_ready` are both high; a low `wr_valid` simply stalls the transfer. On a read beat, the bank port reads combinationally: `bank_rdata` must be valid in the same cycle as the address. `rd_valid` and `rd_data` then hold until `rd_ready` is high, and the bank stays selected for as long as the beat is held.

Addresses are masked to the 8 MB space. A transfer that would run past the end of the space is shortened so that it stops there. After the data of a write, the block pulses `inv_valid` once for each 4 KB page the write touched, in ascending order, so that a texture cache can drop stale lines. Requests are taken only when idle. `done` pulses for one cycle at the end of each transfer.

Top module: `vram_ilv_mapper`

## Requirements
- R1: Request address bits at and above bit ADDR_W (23 by default) are ignored. Only the low ADDR_W bits select the start byte.
- R2: The effective length is the requested length, reduced to 2^ADDR_W minus the start address when it would run past the end of the space.
- R3: Linear byte `a` of a transfer is stored in bank `(a>>2)&1`, at word index `a>>3`, in byte lane `a&3` (bits `8*(a&3)+7 : 8*(a&3)`).
- R4: When the start address is not word aligned, the first beat carries `min(4-off, len)` bytes, where `off = start&3`, and enables lanes `off` upward.
- R5: Whole words take one beat each, with all four byte enables set, and the bank selected for successive whole words alternates.
- R6: When fewer than four bytes remain at a word boundary, the last beat carries them in lanes 0 upward and enables only those lanes.
- R7: Write payload bytes sit packed from lane 0 of `wr_data`, and `beat_bytes` gives the count. A bank write happens only in a cycle where `wr_valid` and `wr_ready` are both high. Lanes of `wr_data` at or above `beat_bytes` have no effect.
- R8: Read payload is returned packed from lane 0 of `rd_data`, with lanes at or above `beat_bytes` zero. `rd_valid` stays high until `rd_ready` is taken.
- R9: After the last data beat of a write with a nonzero effective length, `inv_valid` is high for one cycle per page, with `inv_page` counting up by one from `start>>PAGE_W` to `(start+len-1)>>PAGE_W`. No page strobes are produced for reads or for zero-length writes.
- R10: `req_ready` is high only while idle, and `busy` is high from acceptance until the cycle after `done`. `done` is a one-cycle pulse. A zero-length transfer completes with `done` and makes no bank access.
- R11: At most one bank is enabled in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | REQ_ADDR_W | Start byte address (upper bits ignored) |
| req_len | input | LEN_W | Requested length in bytes |
| req_write | input | 1 | 1 = write transfer, 0 = read transfer |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| beat_bytes | output | CNT_W | Byte count of the current beat |
| wr_valid | input | 1 | Write beat data present |
| wr_ready | output | 1 | Block takes a write beat |
| wr_data | input | DW | Write beat bytes, packed from lane 0 |
| rd_valid | output | 1 | Read beat data present |
| rd_ready | input | 1 | Consumer takes the read beat |
| rd_data | output | DW | Read beat bytes, packed from lane 0 |
| bank_en | output | 2 | Per-bank access enable |
| bank_we | output | 1 | Access is a write |
| bank_addr | output | 2 x WIDX_W | Per-bank word index |
| bank_be | output | NB | Byte-lane enables |
| bank_wdata | output | DW | Lane-aligned write data |
| bank_rdata | input | 2 x DW | Per-bank read data, valid in the same cycle as the address |
| inv_valid | output | 1 | Page invalidate strobe |
| inv_page | output | PG_W | Index of the page being invalidated |

## Verification
A wrong byte pointer or bank flag inside the mapper shows up on the very next beat. It appears as the wrong `bank_en` bit, a `bank_addr` off by one, or a shifted `bank_be`, and then as bytes landing in the wrong bank word. Those bytes are visible in the bank contents as soon as the transfer ends. A remaining-count error ends the transfer early or late, so the accepted byte total disagrees with the clipped length at `done`. A page counter fault shows as a missing, extra or out-of-order `inv_valid` pulse in the cycles just before `done`. Sweeps over every start offset, many short lengths and starts near the top of the space put each of these paths under a known expected result.

// File: rtl/vram_ilv_pkg.sv
package vram_ilv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_INV,
    ST_DONE
  } xfer_state_e;
endpackage

// File: rtl/vram_ilv_clip.sv
// Masks the request address to the space and shortens the length at its end.
module vram_ilv_clip #(
  parameter int ADDR_W     = 23,
  parameter int REQ_ADDR_W = 32,
  parameter int LEN_W      = 24
) (
  input  logic [REQ_ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]      req_len,
  output logic [ADDR_W-1:0]     start,
  output logic [LEN_W-1:0]      len_clip
);
  localparam logic [LEN_W-1:0] SPACE = LEN_W'(1) << ADDR_W;

  logic [LEN_W-1:0] avail;
  logic             unused_hi_bits;

  assign start          = req_addr[ADDR_W-1:0];
  assign unused_hi_bits = ^req_addr[REQ_ADDR_W-1:ADDR_W];
  assign avail          = SPACE - LEN_W'(start);
  assign len_clip       = (req_len > avail) ? avail : req_len;
endmodule

// File: rtl/vram_ilv_beat.sv
// Works out the geometry of the current beat from the byte pointer and the remaining count.
module vram_ilv_beat #(
  parameter int ADDR_W = 23,
  parameter int LEN_W  = 24,
  parameter int NB     = 4,
  localparam int OFF_W  = $clog2(NB),
  localparam int CNT_W  = $clog2(NB + 1),
  localparam int WIDX_W = ADDR_W - OFF_W - 1
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [LEN_W-1:0]  rem,
  output logic [OFF_W-1:0]  off,
  output logic [CNT_W-1:0]  nbytes,
  output logic [NB-1:0]     lanes,
  output logic              bank_sel,
  output logic [WIDX_W-1:0] widx
);
  logic [CNT_W-1:0] room;

  assign off      = cur_addr[OFF_W-1:0];
  assign bank_sel = cur_addr[OFF_W];
  assign widx     = cur_addr[ADDR_W-1:OFF_W+1];
  assign room     = CNT_W'(NB) - CNT_W'(off);
  assign nbytes   = (rem < LEN_W'(room)) ? CNT_W'(rem) : room;

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      lanes[i] = (CNT_W'(i) >= CNT_W'(off)) && (CNT_W'(i) < CNT_W'(off) + nbytes);
    end
  end
endmodule

// File: rtl/vram_ilv_lanes.sv
// Moves stream bytes between lane 0 and the bank byte lanes.
module vram_ilv_lanes #(
  parameter int NB = 4,
  localparam int OFF_W = $clog2(NB),
  localparam int CNT_W = $clog2(NB + 1),
  localparam int DW    = NB * 8
) (
  input  logic [OFF_W-1:0] off,
  input  logic [CNT_W-1:0] nbytes,
  input  logic [DW-1:0]    wr_in,
  input  logic [DW-1:0]    rd_raw,
  output logic [DW-1:0]    wr_out,
  output logic [DW-1:0]    rd_out
);
  logic [DW-1:0] rd_shift;

  assign wr_out   = wr_in << {off, 3'b000};
  assign rd_shift = rd_raw >> {off, 3'b000};

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign rd_out[8*i +: 8] = (CNT_W'(i) < nbytes) ? rd_shift[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/vram_ilv_mapper.sv
module vram_ilv_mapper #(
  parameter int ADDR_W     = 23,
  parameter int REQ_ADDR_W = 32,
  parameter int LEN_W      = 24,
  parameter int PAGE_W     = 12,
  parameter int NB         = 4,
  localparam int DW     = NB * 8,
  localparam int OFF_W  = $clog2(NB),
  localparam int CNT_W  = $clog2(NB + 1),
  localparam int WIDX_W = ADDR_W - OFF_W - 1,
  localparam int PG_W   = ADDR_W - PAGE_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [REQ_ADDR_W-1:0]     req_addr,
  input  logic [LEN_W-1:0]          req_len,
  input  logic                      req_write,
  output logic                      busy,
  output logic                      done,
  output logic [CNT_W-1:0]          beat_bytes,
  input  logic                      wr_valid,
  output logic                      wr_ready,
  input  logic [DW-1:0]             wr_data,
  output logic                      rd_valid,
  input  logic                      rd_ready,
  output logic [DW-1:0]             rd_data,
  output logic [1:0]                bank_en,
  output logic                      bank_we,
  output logic [1:0][WIDX_W-1:0]    bank_addr,
  output logic [NB-1:0]             bank_be,
  output logic [DW-1:0]             bank_wdata,
  input  logic [1:0][DW-1:0]        bank_rdata,
  output logic                      inv_valid,
  output logic [PG_W-1:0]           inv_page
);
  import vram_ilv_pkg::*;

  xfer_state_e       st;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  rem;
  logic              is_wr;
  logic [PG_W-1:0]   pg_cur;
  logic [PG_W-1:0]   pg_last;

  logic [ADDR_W-1:0] start;
  logic [LEN_W-1:0]  len_clip;
  logic [ADDR_W-1:0] end_addr;
  logic [OFF_W-1:0]  off;
  logic [CNT_W-1:0]  nbytes;
  logic [NB-1:0]     lanes;
  logic              bank_sel;
  logic [WIDX_W-1:0] widx;
  logic              active, fire, access, accept, last_beat;

  vram_ilv_clip #(
    .ADDR_W(ADDR_W), .REQ_ADDR_W(REQ_ADDR_W), .LEN_W(LEN_W)
  ) u_clip (
    .req_addr(req_addr), .req_len(req_len), .start(start), .len_clip(len_clip)
  );

  vram_ilv_beat #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .NB(NB)
  ) u_beat (
    .cur_addr(cur_addr), .rem(rem), .off(off), .nbytes(nbytes),
    .lanes(lanes), .bank_sel(bank_sel), .widx(widx)
  );

  vram_ilv_lanes #(
    .NB(NB)
  ) u_lanes (
    .off(off), .nbytes(nbytes), .wr_in(wr_data), .rd_raw(bank_rdata[bank_sel]),
    .wr_out(bank_wdata), .rd_out(rd_data)
  );

  assign end_addr  = start + ADDR_W'(len_clip - LEN_W'(1));
  assign accept    = (st == ST_IDLE) && req_valid;
  assign active    = (st == ST_XFER);
  assign fire      = active && (is_wr ? wr_valid : rd_ready);
  assign access    = is_wr ? fire : active;
  assign last_beat = (rem == LEN_W'(nbytes));

  assign req_ready  = (st == ST_IDLE);
  assign busy       = (st != ST_IDLE);
  assign done       = (st == ST_DONE);
  assign beat_bytes = nbytes;
  assign wr_ready   = active && is_wr;
  assign rd_valid   = active && !is_wr;
  assign bank_we    = active && is_wr;
  assign bank_be    = lanes;
  assign inv_valid  = (st == ST_INV);
  assign inv_page   = pg_cur;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    assign bank_en[b]   = access && (bank_sel == 1'(b));
    assign bank_addr[b] = widx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cur_addr <= '0;
      rem      <= '0;
      is_wr    <= 1'b0;
      pg_cur   <= '0;
      pg_last  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          cur_addr <= start;
          rem      <= len_clip;
          is_wr    <= req_write;
          pg_cur   <= start[ADDR_W-1:PAGE_W];
          pg_last  <= end_addr[ADDR_W-1:PAGE_W];
          st       <= (len_clip == '0) ? ST_DONE : ST_XFER;
        end
        ST_XFER: if (fire) begin
          cur_addr <= cur_addr + ADDR_W'(nbytes);
          rem      <= rem - LEN_W'(nbytes);
          if (last_beat) st <= is_wr ? ST_INV : ST_DONE;
        end
        ST_INV: begin
          pg_cur <= pg_cur + PG_W'(1);
          if (pg_cur == pg_last) st <= ST_DONE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vram_ilv_mapper_chk.sv
module vram_ilv_mapper_chk #(
  parameter int NB    = 4,
  parameter int PG_W  = 11,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             busy,
  input logic             done,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [1:0]       bank_en,
  input logic             bank_we,
  input logic [NB-1:0]    bank_be,
  input logic [CNT_W-1:0] beat_bytes,
  input logic             inv_valid,
  input logic [PG_W-1:0]  inv_page
);
  // R11
  one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(bank_en));

  // R10
  idle_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> !busy);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R7
  wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|bank_en) && bank_we) |-> (wr_valid && wr_ready));

  // R4
  be_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_en) |-> ($countones(bank_be) == int'(beat_bytes)));

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> rd_valid);

  // R9
  inv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && $past(inv_valid)) |-> (inv_page == $past(inv_page) + PG_W'(1)));

  // R9
  inv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) inv_valid |-> !(|bank_en));
endmodule

bind vram_ilv_mapper vram_ilv_mapper_chk #(
  .NB(NB), .PG_W(PG_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .busy(busy), .done(done),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .bank_en(bank_en), .bank_we(bank_we), .bank_be(bank_be), .beat_bytes(beat_bytes),
  .inv_valid(inv_valid), .inv_page(inv_page)
);

// File: tb/vram_ilv_mapper_test.sv
module vram_ilv_mapper_test;
  localparam int PERIOD = 10;
  localparam int AW     = 10;
  localparam int RAW    = 16;
  localparam int LW     = 12;
  localparam int PW     = 6;
  localparam int NB     = 4;
  localparam int DW     = 32;
  localparam int WIW    = AW - 3;
  localparam int PGW    = AW - PW;
  localparam int CW     = 3;
  localparam int SPACE  = 1 << AW;
  localparam int BWORDS = 1 << WIW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [RAW-1:0] req_addr = '0;
  logic [LW-1:0]  req_len = '0;
  logic req_write = 1'b0;
  logic busy, done;
  logic [CW-1:0] beat_bytes;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [DW-1:0] wr_data = '0;
  logic rd_valid;
  logic rd_ready = 1'b0;
  logic [DW-1:0] rd_data;
  logic [1:0] bank_en;
  logic bank_we;
  logic [1:0][WIW-1:0] bank_addr;
  logic [NB-1:0] bank_be;
  logic [DW-1:0] bank_wdata;
  logic [1:0][DW-1:0] bank_rdata;
  logic inv_valid;
  logic [PGW-1:0] inv_page;

  int checks = 0;
  int fails = 0;
  int inv_cnt = 0;
  int en_cnt = 0;
  int inv_log [32];
  logic [7:0] img [SPACE];
  logic [DW-1:0] bmem [2][BWORDS];

  always #(PERIOD/2) clk = ~clk;

  vram_ilv_mapper #(
    .ADDR_W(AW), .REQ_ADDR_W(RAW), .LEN_W(LW), .PAGE_W(PW), .NB(NB)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_write(req_write),
    .busy(busy), .done(done), .beat_bytes(beat_bytes),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .bank_en(bank_en), .bank_we(bank_we), .bank_addr(bank_addr), .bank_be(bank_be),
    .bank_wdata(bank_wdata), .bank_rdata(bank_rdata),
    .inv_valid(inv_valid), .inv_page(inv_page)
  );

  // bank models: synchronous byte-enabled write, combinational read
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int w = 0; w < BWORDS; w++) bmem[b][w] <= '0;
    end else begin
      for (int b = 0; b < 2; b++)
        if (bank_en[b] && bank_we)
          for (int j = 0; j < NB; j++)
            if (bank_be[j]) bmem[b][bank_addr[b]][8*j +: 8] <= bank_wdata[8*j +: 8];
    end
  end

  always_comb begin
    for (int b = 0; b < 2; b++) bank_rdata[b] = bmem[b][bank_addr[b]];
  end

  always @(negedge clk) begin
    if (inv_valid) begin
      inv_log[inv_cnt % 32] = int'(inv_page);
      inv_cnt = inv_cnt + 1;
    end
    #2;
    if (|bank_en) en_cnt = en_cnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dv(input int k, input int seed);
    return 8'((k * 13 + seed * 29 + 1) & 255);
  endfunction

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic mem_compare(input string tag);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < SPACE; i++) begin
      if (bmem[(i >> 2) & 1][i >> 3][8*(i & 3) +: 8] !== img[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    end
    chk(bad == 0, tag, first, -1);
  endtask

  task automatic do_write(input int areq, input int len, input int seed,
                          input bit stall, input string mtag);
    int a, l, k, cyc, inv0, en0, off, nexp, sel, npg, pa;
    int bad_lead, bad_word, bad_tail, bad_one;
    bit saw_lead, saw_word, saw_tail;
    a = areq & (SPACE - 1);
    l = imin(len, SPACE - a);
    inv0 = inv_cnt; en0 = en_cnt;
    bad_lead = 0; bad_word = 0; bad_tail = 0; bad_one = 0;
    saw_lead = 0; saw_word = 0; saw_tail = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = RAW'(areq); req_len = LW'(len); req_write = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1 && req_ready == 1'b0, "R10 busy after accept", int'(busy), 1);
    k = 0; cyc = 0;
    while (!done) begin
      wr_valid = !(stall && (cyc % 3 == 1));
      off = (a + k) & 3;
      nexp = imin(4 - off, l - k);
      wr_data = 32'hA5A5A5A5;
      for (int j = 0; j < NB; j++) if (j < nexp) wr_data[8*j +: 8] = dv(k + j, seed);
      #1;
      if (wr_valid && wr_ready) begin
        sel = ((a + k) >> 2) & 1;
        if ($countones(bank_en) > 1) bad_one++;
        if (!(int'(beat_bytes) == nexp && bank_en == 2'(1 << sel) &&
              int'(bank_addr[sel]) == ((a + k) >> 3) &&
              int'(bank_be) == (((1 << nexp) - 1) << off))) begin
          if (off != 0) bad_lead++;
          else if (nexp == 4) bad_word++;
          else bad_tail++;
        end
        if (off != 0) saw_lead = 1;
        else if (nexp == 4) saw_word = 1;
        else saw_tail = 1;
        for (int j = 0; j < nexp; j++) img[a + k + j] = dv(k + j, seed);
        k += nexp;
      end
      @(negedge clk);
      cyc++;
    end
    wr_valid = 1'b0;
    chk(k == l, "R7 bytes accepted on write", k, l);
    if (len > SPACE - a) chk(k == SPACE - a, "R2 write clipped at end of space", k, SPACE - a);
    mem_compare(mtag);
    if (saw_lead) chk(bad_lead == 0, "R4 leading fragment beat", bad_lead, 0);
    if (saw_word) chk(bad_word == 0, "R5 whole word beat", bad_word, 0);
    if (saw_tail) chk(bad_tail == 0, "R6 trailing fragment beat", bad_tail, 0);
    chk(bad_one == 0, "R11 single bank per beat", bad_one, 0);
    npg = (l == 0) ? 0 : ((a + l - 1) >> PW) - (a >> PW) + 1;
    chk(inv_cnt - inv0 == npg, "R9 page strobe count", inv_cnt - inv0, npg);
    pa = a >> PW;
    for (int i = 0; i < npg && i < 32; i++)
      chk(inv_log[(inv0 + i) % 32] == pa + i, "R9 page strobe order",
          inv_log[(inv0 + i) % 32], pa + i);
    if (l == 0) chk(en_cnt == en0, "R10 zero length makes no access", en_cnt - en0, 0);
    @(negedge clk);
    chk(done == 1'b0 && req_ready == 1'b1, "R10 done is one pulse", int'(done), 0);
  endtask

  task automatic do_read(input int areq, input int len, input bit stall);
    int a, l, k, cyc, inv0, off, nexp, bad;
    a = areq & (SPACE - 1);
    l = imin(len, SPACE - a);
    inv0 = inv_cnt; bad = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = RAW'(areq); req_len = LW'(len); req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    k = 0; cyc = 0;
    while (!done) begin
      rd_ready = !(stall && (cyc % 3 == 1));
      off = (a + k) & 3;
      nexp = imin(4 - off, l - k);
      #1;
      if (rd_valid && rd_ready) begin
        if (int'(beat_bytes) != nexp) bad++;
        for (int j = 0; j < NB; j++) begin
          if (j < nexp) begin
            if (rd_data[8*j +: 8] !== img[a + k + j]) bad++;
          end else if (rd_data[8*j +: 8] !== 8'h00) bad++;
        end
        k += nexp;
      end
      @(negedge clk);
      cyc++;
    end
    rd_ready = 1'b0;
    chk(bad == 0, "R8 read bytes packed from lane 0", bad, 0);
    chk(k == l, "R8 bytes returned on read", k, l);
    if (len > SPACE - a) chk(k == SPACE - a, "R2 read clipped at end of space", k, SPACE - a);
    chk(inv_cnt == inv0, "R9 no page strobes on read", inv_cnt - inv0, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < SPACE; i++) img[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && req_ready == 1'b1 && done == 1'b0, "R10 reset state", int'(busy), 0);
    chk(inv_valid == 1'b0 && bank_en == 2'b00 && !wr_ready && !rd_valid,
        "R11 reset quiet", int'(bank_en), 0);

    for (int a = 0; a < 20; a++)
      for (int l = 0; l < 14; l++) do_write(a, l, a * 14 + l, ((a + l) & 1) == 1, "R3");
    for (int a = 0; a < 20; a++)
      for (int l = 0; l < 14; l++) do_read(a, l, (l & 1) == 1);

    for (int a = SPACE - 14; a < SPACE; a++) begin
      do_write(a, 20, a, 1'b0, "R3");
      do_read(a, 30, 1'b1);
    end
    do_write(SPACE - 3, 2000, 7, 1'b1, "R3");

    for (int a = 120; a < 128; a++) do_write(16'hFC00 | a, 9, a + 3, 1'b0, "R1 upper address bits ignored");
    do_read(16'hA800 | 120, 16, 1'b0);

    do_write(5, SPACE, 11, 1'b1, "R3");
    do_read(0, SPACE, 1'b1);
    do_write(64 - 2, 5, 12, 1'b0, "R3");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule